// File: doc/BRIEF.md
# Key Matrix Scanner with Two-Frame Confirmation

This block scans a key matrix of eight source lines and four input lines. A display drive sequencer gives it one scan start pulse per frame. On each pulse the block drives the sources one after another. Each source is held for a fixed number of clock cycles. While a source is driven, the block enables the pull-downs on the input lines. It samples the four inputs in the last cycle of each source window. When all eight windows are done, the block has a fresh 32-bit image of the matrix.

A fresh image counts as confirmed only when it equals the image taken in the previous frame. Confirmation therefore needs at least two frames after a key changes. A key-request flag is high while the confirmed image holds any pressed key.

A host reads the image through a small serial port. A load strobe copies the confirmed image into a readout register, but only while the key-request flag is high. Each shift strobe then presents the next bit, most significant bit first. The sequencer drops the scan enable while the display is forced off or after a display-setting command. This stops scanning at once and clears the confirmation history.

Top module: `key_scan_confirm`

## Requirements
- R1: After reset, `key_src_o` is all zero and `pull_en_o`, `key_req_o` and `sdo_o` are low.
- R2: A `scan_start_i` pulse taken while `scan_en_i` is high and no scan is running drives the sources in the order bit 0 to bit 7 of `key_src_o`. Exactly one bit is set at a time, and each source is held for `SRC_CYCLES` cycles. `pull_en_o` is high exactly while a source is driven.
- R3: Source s (1..8) with input k (1..4) maps to image bit (s-1)*4+(k-1). Bit 31 is source 8, input 4. A pressed key reads as 1 and a released key as 0, and readout is MSB first.
- R4: A completed frame image becomes the confirmed image only if it equals the image of the previous completed frame. The first frame after reset, or after scan enable returns, never confirms.
- R5: `key_req_o` is high exactly when the confirmed image is nonzero, and falls once a confirmed all-zero image is taken.
- R6: While `scan_en_i` is low, any running scan is aborted, all sources are off the next cycle, and start pulses are ignored.
- R7: `load_i` copies the confirmed image into the readout register only while `key_req_o` is high; otherwise the register keeps its content. Each `shift_i` cycle (without `load_i`) moves the next lower bit onto `sdo_o`.
- R8: A start pulse that arrives while a scan is running has no effect on the source sequence.
- R9: Each key input is taken only in the last cycle of its source window. Values on the input lines earlier in the window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scan_en_i | input | 1 | Scanning allowed (low when display forced off or after setting command) |
| scan_start_i | input | 1 | Per-frame key-scan slot start pulse from the drive sequencer |
| key_in_i | input | 4 | Key input lines |
| key_src_o | output | 8 | One-hot key source drive |
| pull_en_o | output | 1 | Input pull-down enable |
| key_req_o | output | 1 | Confirmed image holds a pressed key |
| load_i | input | 1 | Copy confirmed image into readout register |
| shift_i | input | 1 | Advance readout by one bit |
| sdo_o | output | 1 | Serial readout bit, MSB first |

## Verification
The bench sweeps every source/input position on its own and checks the readout against the bit index it computes. A swapped source or input order would move that bit elsewhere. It sends a changed image for only one frame to show that a design comparing against the wrong frame would confirm too early. It also confirms right after re-enable to show that a design keeping its history across a disable would do the same. Inverted noise on the inputs in every cycle but the last of each window exposes a design that samples early. Load strobes while no key is confirmed, start pulses during a scan, and a mid-scan disable check that none of these corrupts the held image or the source sequence.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  localparam int unsigned NUM_SRC = 8;
  localparam int unsigned NUM_IN  = 4;
  localparam int unsigned IMG_W   = NUM_SRC * NUM_IN;
endpackage

// File: rtl/kscan_seq.sv
module kscan_seq #(
  parameter int unsigned N_SRC      = 8,
  parameter int unsigned SRC_CYCLES = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scan_en_i,
  input  logic                     scan_start_i,
  output logic [N_SRC-1:0]         src_o,
  output logic                     busy_o,
  output logic                     samp_o,
  output logic                     done_o,
  output logic [$clog2(N_SRC)-1:0] idx_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam int unsigned CNT_W = (SRC_CYCLES > 1) ? $clog2(SRC_CYCLES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SRC - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SRC_CYCLES - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  assign samp_o = busy_q && (cnt_q == LAST_CNT);
  assign done_o = samp_o && (idx_q == LAST_IDX);
  assign busy_o = busy_q;
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (!scan_en_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (scan_start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        cnt_q  <= '0;
      end
    end else if (samp_o) begin
      cnt_q <= '0;
      if (done_o) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_o[s] = busy_q && (idx_q == IDX_W'(s));
  end
endmodule

// File: rtl/kscan_confirm.sv
module kscan_confirm #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned N_IN  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scan_en_i,
  input  logic                     samp_i,
  input  logic                     done_i,
  input  logic [$clog2(N_SRC)-1:0] idx_i,
  input  logic [N_IN-1:0]          key_in_i,
  output logic [N_SRC*N_IN-1:0]    conf_o
);
  localparam int unsigned IMG_W = N_SRC * N_IN;
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [IMG_W-1:0] snap_q, snap_d, prev_q, conf_q;
  logic             prev_vld_q;

  for (genvar s = 0; s < N_SRC; s++) begin : g_slice
    assign snap_d[s*N_IN +: N_IN] = (samp_i && idx_i == IDX_W'(s)) ?
                                    key_in_i : snap_q[s*N_IN +: N_IN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q     <= '0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      conf_q     <= '0;
    end else if (!scan_en_i) begin
      prev_vld_q <= 1'b0;
    end else begin
      snap_q <= snap_d;
      if (done_i) begin
        // two equal consecutive frames confirm
        if (prev_vld_q && (snap_d == prev_q)) conf_q <= snap_d;
        prev_q     <= snap_d;
        prev_vld_q <= 1'b1;
      end
    end
  end

  assign conf_o = conf_q;
endmodule

// File: rtl/kscan_readout.sv
module kscan_readout #(
  parameter int unsigned IMG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             allow_i,
  input  logic [IMG_W-1:0] img_i,
  output logic             sdo_o
);
  logic [IMG_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sh_q <= '0;
    else if (load_i && allow_i) sh_q <= img_i;
    else if (shift_i && !load_i) sh_q <= {sh_q[IMG_W-2:0], 1'b0};
  end

  assign sdo_o = sh_q[IMG_W-1];
endmodule

// File: rtl/key_scan_confirm.sv
module key_scan_confirm
  import kscan_pkg::*;
#(
  parameter int unsigned N_SRC      = NUM_SRC,
  parameter int unsigned N_IN       = NUM_IN,
  parameter int unsigned SRC_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_en_i,
  input  logic             scan_start_i,
  input  logic [N_IN-1:0]  key_in_i,
  output logic [N_SRC-1:0] key_src_o,
  output logic             pull_en_o,
  output logic             key_req_o,
  input  logic             load_i,
  input  logic             shift_i,
  output logic             sdo_o
);
  localparam int unsigned IMG_W = N_SRC * N_IN;
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic             busy, samp, done;
  logic [IDX_W-1:0] idx;
  logic [IMG_W-1:0] conf;

  kscan_seq #(.N_SRC(N_SRC), .SRC_CYCLES(SRC_CYCLES)) u_seq (
    .clk_i, .rst_ni, .scan_en_i, .scan_start_i,
    .src_o(key_src_o), .busy_o(busy), .samp_o(samp), .done_o(done), .idx_o(idx)
  );

  kscan_confirm #(.N_SRC(N_SRC), .N_IN(N_IN)) u_conf (
    .clk_i, .rst_ni, .scan_en_i, .samp_i(samp), .done_i(done), .idx_i(idx),
    .key_in_i, .conf_o(conf)
  );

  assign key_req_o = |conf;
  assign pull_en_o = busy;

  kscan_readout #(.IMG_W(IMG_W)) u_rd (
    .clk_i, .rst_ni, .load_i, .shift_i, .allow_i(key_req_o), .img_i(conf), .sdo_o
  );
endmodule

// File: rtl/key_scan_confirm_chk.sv
module key_scan_confirm_chk #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned N_IN  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scan_en_i,
  input logic [N_SRC-1:0] key_src_o,
  input logic             pull_en_o,
  input logic             key_req_o,
  input logic             load_i,
  input logic             shift_i,
  input logic             sdo_o
);
  a_r2_src_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(key_src_o));

  a_r2_pull_tracks_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_en_o == (key_src_o != '0));

  a_r2_src_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_src_o != '0 && $past(key_src_o) != '0 && key_src_o != $past(key_src_o))
    |-> key_src_o == ($past(key_src_o) << 1));

  a_r6_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |=> key_src_o == '0);

  // R4/R5: request moves only at the end of a scan
  a_r4_req_rise_after_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_req_o) |-> $past(pull_en_o));

  a_r5_req_fall_after_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(key_req_o) |-> $past(pull_en_o));

  a_r7_load_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !key_req_o && !shift_i) |=> $stable(sdo_o));
endmodule

bind key_scan_confirm key_scan_confirm_chk #(.N_SRC(N_SRC), .N_IN(N_IN)) u_chk (
  .clk_i, .rst_ni, .scan_en_i, .key_src_o, .pull_en_o, .key_req_o,
  .load_i, .shift_i, .sdo_o
);

// File: tb/key_scan_confirm_tb.sv
module key_scan_confirm_tb;
  localparam int NS = 8;
  localparam int NI = 4;
  localparam int SC = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          scan_en = 1'b1;
  logic          scan_start = 1'b0;
  logic [NI-1:0] key_in;
  logic [NS-1:0] key_src;
  logic          pull_en, key_req, load = 1'b0, shift = 1'b0, sdo;

  logic [31:0] img = '0;
  logic        noise = 1'b0;
  logic [NS-1:0] prev_src = '0;
  int          win_cnt = 0;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  key_scan_confirm #(.N_SRC(NS), .N_IN(NI), .SRC_CYCLES(SC)) u_dut (
    .clk_i(clk), .rst_ni, .scan_en_i(scan_en), .scan_start_i(scan_start),
    .key_in_i(key_in), .key_src_o(key_src), .pull_en_o(pull_en),
    .key_req_o(key_req), .load_i(load), .shift_i(shift), .sdo_o(sdo)
  );

  // matrix model with optional inverted noise before the last window cycle
  always @(negedge clk) begin
    logic [NI-1:0] v;
    if (key_src != prev_src) win_cnt = 0; else win_cnt = win_cnt + 1;
    prev_src = key_src;
    v = '0;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NI; k++)
        if (key_src[s] && img[s*NI+k]) v[k] = 1'b1;
    if (noise && key_src != '0 && win_cnt < SC-1) v = ~v;
    key_in = v;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_frame();
    @(negedge clk) scan_start = 1'b1;
    @(negedge clk) scan_start = 1'b0;
    repeat (NS*SC + 2) @(negedge clk);
  endtask

  task automatic read_img(input bit do_load, output logic [31:0] v);
    if (do_load) begin
      @(negedge clk) load = 1'b1;
      @(negedge clk) load = 1'b0;
    end
    v = '0;
    shift = 1'b1;
    for (int i = 0; i < 32; i++) begin
      v = {v[30:0], sdo};
      @(negedge clk);
    end
    shift = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(key_src == '0 && !pull_en && !key_req && !sdo, "R1",
        {key_src, 21'd0, pull_en, key_req, sdo}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 order and timing, R8 start during scan ignored
    @(negedge clk) scan_start = 1'b1;
    @(negedge clk) scan_start = 1'b0;
    for (int k = 0; k <= NS*SC; k++) begin
      logic [NS-1:0] e;
      e = (k < NS*SC) ? NS'(1) << (k / SC) : '0;
      chk(key_src == e && pull_en == (e != '0), (k == 6) ? "R8" : "R2",
          {23'd0, pull_en, key_src}, {23'd0, e != '0, e});
      if (k == 5) scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
    end
    repeat (2) @(negedge clk);

    // R4: changed image for one frame does not confirm
    img = 32'h8000_0001;
    run_frame();
    chk(!key_req, "R4", {31'd0, key_req}, 32'd0);
    run_frame();
    chk(key_req, "R5", {31'd0, key_req}, 32'd1);
    read_img(1, rd);
    chk(rd == img, "R3", rd, img);

    // R3 sweep over every source/input position
    for (int s = 1; s <= NS; s++)
      for (int k = 1; k <= NI; k++) begin
        logic [31:0] e;
        e = 32'd1 << ((s-1)*4 + (k-1));
        img = e;
        run_frame();
        run_frame();
        read_img(1, rd);
        chk(rd == e && key_req, "R3", rd, e);
      end

    // R4: one-frame glitch keeps old confirmed image
    img = 32'h1234_5678; run_frame(); run_frame();
    img = 32'h0F0F_00A5; run_frame();
    img = 32'h1234_5678; run_frame();
    read_img(1, rd);
    chk(rd == 32'h1234_5678, "R4", rd, 32'h1234_5678);

    // R6: abort mid-scan, starts ignored, history cleared
    img = 32'hA5A5_0001;
    @(negedge clk) scan_start = 1'b1;
    @(negedge clk) scan_start = 1'b0;
    repeat (9) @(negedge clk);
    scan_en = 1'b0;
    @(negedge clk);
    chk(key_src == '0 && !pull_en, "R6", {24'd0, key_src}, 32'd0);
    scan_start = 1'b1;
    repeat (3) @(negedge clk);
    scan_start = 1'b0;
    chk(key_src == '0, "R6", {24'd0, key_src}, 32'd0);
    scan_en = 1'b1;
    @(negedge clk);
    run_frame();
    read_img(1, rd);
    chk(rd == 32'h1234_5678, "R4", rd, 32'h1234_5678);
    run_frame();
    read_img(1, rd);
    chk(rd == 32'hA5A5_0001, "R4", rd, 32'hA5A5_0001);

    // R9: noise before last window cycle has no effect
    noise = 1'b1;
    img = 32'h3C96_E11B; run_frame(); run_frame();
    noise = 1'b0;
    read_img(1, rd);
    chk(rd == 32'h3C96_E11B, "R9", rd, 32'h3C96_E11B);

    // R7/R5: load a value, then confirm all-zero; later loads ignored
    held = 32'h3C96_E11B;
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    img = '0; run_frame(); run_frame();
    chk(!key_req, "R5", {31'd0, key_req}, 32'd0);
    chk(sdo == held[31], "R7", {31'd0, sdo}, {31'd0, held[31]});
    read_img(1, rd);
    chk(rd == held, "R7", rd, held);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule